// File: doc/BRIEF.md
# Coulomb Counter Register Bank

This block keeps the running totals of a battery charge monitor. An external converter model delivers one pulse per quantum of charge moved into or out of the cell. The block accumulates those pulses in a discharge count and a charge count. It also measures how long each flow direction has lasted, and it estimates self-discharge from elapsed time and the present temperature step. A host reads and maintains all of this through a byte-wide address/data strobe port.

The two time counters are each run by a two-state machine. In TC_FAST they advance on every base tick. A rollover past FFFFh moves them to TC_SLOW, where one count is made per 256 ticks and a sticky slow flag shows in the mode register. A further rollover while in TC_SLOW returns the counter to TC_FAST, and a host clear also forces TC_FAST. Host clears are handled by a second machine. A write of nonzero clear bits moves it from CLR_IDLE to CLR_APPLY. In CLR_APPLY the selected counters are zeroed on the next edge, and the machine drops back to CLR_IDLE, which zeroes the clear bits. If another clear write arrives during CLR_APPLY, the machine stays in CLR_APPLY.

The self-discharge counter uses a free-running tick prescaler, and the temperature step selects how often it advances. All counting stops while the sleep flag is high, and that includes every prescaler.

Top module: `coulomb_regbank`

## Requirements
- R1: After reset all five counters read 0000h, the mode register (75h) reads 0Eh, the offset register (73h) reads 00h and the clear bits of 74h read 0.
- R2: Each cycle with `dsg_pulse` high adds 1 to the discharge count (high byte 7Fh, low byte 7Eh). Each cycle with `chg_pulse` high adds 1 to the charge count (high 7Dh, low 7Ch). Both may increment in the same cycle.
- R3: While `dsg_on` is high, each `tick` cycle adds 1 to the discharge time (high 79h, low 78h). While `chg_on` is high, each `tick` cycle adds 1 to the charge time (high 77h, low 76h).
- R4: When a time counter rolls over from FFFFh to 0000h, its slow flag is set: mode bit 4 for discharge time, mode bit 5 for charge time. After that the counter advances once per 256 ticks.
- R5: The self-discharge count (high 7Bh, low 7Ah) advances once every 2^(15-T) ticks, where T is `temp_step` (0 for the coldest step, 7 for the hottest). Bits 7:5 of 74h read back T.
- R6: Bits 0 to 4 of a write to 74h select the discharge count, charge count, self-discharge count, discharge time and charge time. Each selected counter is zeroed on the edge after the write. A read issued right after the write returns the bits as 1, and later reads return 0. Clearing a time counter also clears its slow flag and restarts its 256-tick prescaler. Clearing the self-discharge count restarts its prescaler.
- R7: Mode bits 7, 6 and 3:1 are read/write. Bits 5:4 show the slow flags and ignore writes. Bit 0 always reads 0.
- R8: The offset register at 73h stores and returns any 8-bit value.
- R9: Reading a low-byte counter address latches the matching high byte. The next high-byte read returns that latched value, even if the counter has changed since.
- R10: Writes to the counter addresses 76h to 7Fh have no effect.
- R11: While `sleep` is high no counter or prescaler advances.
- R12: Read data appears on `rdata` one edge after `rd_en` and holds until the next read. Addresses 72h and below read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsg_pulse | input | 1 | One discharge quantum this cycle |
| chg_pulse | input | 1 | One charge quantum this cycle |
| dsg_on | input | 1 | Discharge current is flowing |
| chg_on | input | 1 | Charge current is flowing |
| tick | input | 1 | Base time tick, 4096 per hour |
| temp_step | input | 3 | Temperature step code |
| sleep | input | 1 | Suspend all counting |
| addr | input | 7 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
A pulse or tick that is high before an edge changes its counter at that edge. A register read started at a negative edge has its byte on `rdata` at the following negative edge, so the bench drives every input and samples every output on falling edges. A clear write is captured at one rising edge and carried out at the next. The bench therefore reads 74h straight after the write to see the bits set, but waits one extra cycle before reading the cleared counters. Tick-dependent results are checked one tick before and exactly at each expected step, using periods computed by bench functions.

// File: rtl/cc_pkg.sv
`timescale 1ns/1ps
package cc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam int N_CLR  = 5;

    // clear-bit positions
    localparam int CLR_DCR = 0;
    localparam int CLR_DTC = 3;
    localparam int CLR_SCR = 2;

    localparam logic [ADDR_W-1:0] A_OFS   = 7'h73;
    localparam logic [ADDR_W-1:0] A_CLR   = 7'h74;
    localparam logic [ADDR_W-1:0] A_MODE  = 7'h75;
    localparam logic [ADDR_W-1:0] A_CTC_L = 7'h76;
    localparam logic [ADDR_W-1:0] A_CTC_H = 7'h77;
    localparam logic [ADDR_W-1:0] A_DTC_L = 7'h78;
    localparam logic [ADDR_W-1:0] A_DTC_H = 7'h79;
    localparam logic [ADDR_W-1:0] A_SCR_L = 7'h7A;
    localparam logic [ADDR_W-1:0] A_SCR_H = 7'h7B;
    localparam logic [ADDR_W-1:0] A_CCR_L = 7'h7C;
    localparam logic [ADDR_W-1:0] A_CCR_H = 7'h7D;
    localparam logic [ADDR_W-1:0] A_DCR_L = 7'h7E;
    localparam logic [ADDR_W-1:0] A_DCR_H = 7'h7F;

    typedef enum logic {TC_FAST, TC_SLOW} tc_state_e;
    typedef enum logic {CLR_IDLE, CLR_APPLY} clr_state_e;
endpackage

// File: rtl/cc_event_counter.sv
`timescale 1ns/1ps
module cc_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/cc_time_counter.sv
`timescale 1ns/1ps
module cc_time_counter
    import cc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SLOW_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             slow
);
    tc_state_e            state, state_nxt;
    logic [SLOW_LOG2-1:0] pre;
    logic                 step;
    logic                 wrap;

    always_comb begin
        step = 1'b0;
        unique case (state)
            TC_FAST: step = tick_en;
            TC_SLOW: step = tick_en && (&pre);
        endcase
        wrap      = step && (&count);
        state_nxt = state;
        if (clr) begin
            state_nxt = TC_FAST;
        end else if (wrap) begin
            unique case (state)
                TC_FAST: state_nxt = TC_SLOW;
                TC_SLOW: state_nxt = TC_FAST;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TC_FAST;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            pre   <= '0;
        end else if (clr) begin
            count <= '0;
            pre   <= '0;
        end else begin
            if (step) count <= count + 1'b1;
            if (tick_en && state == TC_SLOW) pre <= pre + 1'b1;
        end
    end

    assign slow = (state == TC_SLOW);
endmodule

// File: rtl/cc_self_discharge.sv
`timescale 1ns/1ps
module cc_self_discharge #(
    parameter int CNT_W     = 16,
    parameter int TEMP_W    = 3,
    parameter int HOUR_LOG2 = 12,
    parameter int MID_STEP  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [TEMP_W-1:0] temp,
    input  logic              clr,
    output logic [CNT_W-1:0]  count
);
    localparam int PRE_W = HOUR_LOG2 + MID_STEP;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] mask;
    logic             step;

    // period 2^(PRE_W - temp) ticks
    assign mask = {PRE_W{1'b1}} >> temp;
    assign step = tick_en && ((pre & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre   <= '0;
            count <= '0;
        end else if (clr) begin
            pre   <= '0;
            count <= '0;
        end else begin
            if (tick_en) pre   <= pre + 1'b1;
            if (step)    count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/coulomb_regbank.sv
`timescale 1ns/1ps
module coulomb_regbank
    import cc_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SLOW_LOG2 = 8,
    parameter int HOUR_LOG2 = 12,
    parameter int TEMP_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsg_pulse,
    input  logic              chg_pulse,
    input  logic              dsg_on,
    input  logic              chg_on,
    input  logic              tick,
    input  logic [TEMP_W-1:0] temp_step,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int N_DIR = 2;

    logic             run;
    logic [N_DIR-1:0] ev_inc, tm_en, tm_slow;
    logic [CNT_W-1:0] ev_cnt [N_DIR];
    logic [CNT_W-1:0] tm_cnt [N_DIR];
    logic [CNT_W-1:0] dcr_q, ccr_q, scr_q, dtc_q, ctc_q;
    logic             std_q, stc_q;

    clr_state_e       clr_state, clr_state_nxt;
    logic [N_CLR-1:0] clr_pend, clr_vec;
    logic             clr_wr;

    logic             mode_ovr, mode_cal;
    logic [2:0]       mode_woe;
    logic [DATA_W-1:0] ofs_q, rd_val, pair_hi, shadow;
    logic             rd_low;

    assign run    = !sleep;
    assign ev_inc = {chg_pulse, dsg_pulse} & {N_DIR{run}};
    assign tm_en  = {chg_on, dsg_on} & {N_DIR{tick && run}};

    // index 0 = discharge, 1 = charge
    for (genvar gi = 0; gi < N_DIR; gi++) begin : g_dir
        cc_event_counter #(.CNT_W(CNT_W)) u_ev (
            .clk(clk), .rst_n(rst_n), .inc(ev_inc[gi]),
            .clr(clr_vec[CLR_DCR + gi]), .count(ev_cnt[gi])
        );
        cc_time_counter #(.CNT_W(CNT_W), .SLOW_LOG2(SLOW_LOG2)) u_tm (
            .clk(clk), .rst_n(rst_n), .tick_en(tm_en[gi]),
            .clr(clr_vec[CLR_DTC + gi]), .count(tm_cnt[gi]), .slow(tm_slow[gi])
        );
    end

    cc_self_discharge #(.CNT_W(CNT_W), .TEMP_W(TEMP_W), .HOUR_LOG2(HOUR_LOG2)) u_sd (
        .clk(clk), .rst_n(rst_n), .tick_en(tick && run), .temp(temp_step),
        .clr(clr_vec[CLR_SCR]), .count(scr_q)
    );

    assign dcr_q = ev_cnt[0];
    assign ccr_q = ev_cnt[1];
    assign dtc_q = tm_cnt[0];
    assign ctc_q = tm_cnt[1];
    assign std_q = tm_slow[0];
    assign stc_q = tm_slow[1];

    // clear sequencer: next state
    always_comb begin
        clr_wr        = wr_en && (addr == A_CLR) && (|wdata[N_CLR-1:0]);
        clr_state_nxt = clr_state;
        unique case (clr_state)
            CLR_IDLE:  if (clr_wr)  clr_state_nxt = CLR_APPLY;
            CLR_APPLY: if (!clr_wr) clr_state_nxt = CLR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_state <= CLR_IDLE;
        else        clr_state <= clr_state_nxt;
    end

    // clear sequencer: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       clr_pend <= '0;
        else if (clr_wr)                  clr_pend <= wdata[N_CLR-1:0];
        else if (clr_state == CLR_APPLY)  clr_pend <= '0;
    end

    assign clr_vec = (clr_state == CLR_APPLY) ? clr_pend : '0;

    // host-writable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_ovr <= 1'b0;
            mode_cal <= 1'b0;
            mode_woe <= 3'b111;
            ofs_q    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_MODE: begin
                    mode_ovr <= wdata[7];
                    mode_cal <= wdata[6];
                    mode_woe <= wdata[3:1];
                end
                A_OFS:   ofs_q <= wdata;
                default: ;
            endcase
        end
    end

    // read mux
    always_comb begin
        rd_val  = '0;
        pair_hi = '0;
        rd_low  = 1'b0;
        case (addr)
            A_DCR_L: begin rd_val = dcr_q[DATA_W-1:0]; pair_hi = dcr_q[CNT_W-1 -: DATA_W]; rd_low = 1'b1; end
            A_CCR_L: begin rd_val = ccr_q[DATA_W-1:0]; pair_hi = ccr_q[CNT_W-1 -: DATA_W]; rd_low = 1'b1; end
            A_SCR_L: begin rd_val = scr_q[DATA_W-1:0]; pair_hi = scr_q[CNT_W-1 -: DATA_W]; rd_low = 1'b1; end
            A_DTC_L: begin rd_val = dtc_q[DATA_W-1:0]; pair_hi = dtc_q[CNT_W-1 -: DATA_W]; rd_low = 1'b1; end
            A_CTC_L: begin rd_val = ctc_q[DATA_W-1:0]; pair_hi = ctc_q[CNT_W-1 -: DATA_W]; rd_low = 1'b1; end
            A_DCR_H, A_CCR_H, A_SCR_H, A_DTC_H, A_CTC_H: rd_val = shadow;
            A_MODE:  rd_val = {mode_ovr, mode_cal, stc_q, std_q, mode_woe, 1'b0};
            A_CLR:   rd_val = {temp_step, clr_pend};
            A_OFS:   rd_val = ofs_q;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            shadow <= '0;
        end else if (rd_en) begin
            rdata <= rd_val;
            if (rd_low) shadow <= pair_hi;
        end
    end
endmodule

// File: rtl/coulomb_regbank_chk.sv
`timescale 1ns/1ps
module coulomb_regbank_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             dsg_pulse,
    input logic [4:0]       clr_vec,
    input logic [CNT_W-1:0] dcr,
    input logic [CNT_W-1:0] ccr,
    input logic [CNT_W-1:0] scr,
    input logic [CNT_W-1:0] dtc,
    input logic [CNT_W-1:0] ctc,
    input logic             std
);
    // R11
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && clr_vec == 5'd0) |=> ($stable(dcr) && $stable(ccr) && $stable(scr)
                                        && $stable(dtc) && $stable(ctc)));

    // R2
    dsg_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && dsg_pulse && !clr_vec[0]) |=> (dcr == CNT_W'($past(dcr) + 1'b1)));

    // R6
    dcr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vec[0] |=> (dcr == '0));

    // R6
    dtc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vec[3] |=> (dtc == '0 && !std));

    // R4
    slow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(std) |-> (dtc == '0 && $past(dtc) == {CNT_W{1'b1}}));
endmodule

bind coulomb_regbank coulomb_regbank_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .dsg_pulse(dsg_pulse),
    .clr_vec(clr_vec), .dcr(dcr_q), .ccr(ccr_q), .scr(scr_q),
    .dtc(dtc_q), .ctc(ctc_q), .std(std_q)
);

// File: tb/coulomb_regbank_bench.sv
`timescale 1ns/1ps
module coulomb_regbank_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dsg_pulse = 1'b0, chg_pulse = 1'b0, dsg_on = 1'b0, chg_on = 1'b0;
    logic       tick = 1'b0, sleep = 1'b0;
    logic [2:0] temp_step = 3'd3;
    logic [6:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    coulomb_regbank u_coulomb_regbank (
        .clk(clk), .rst_n(rst_n), .dsg_pulse(dsg_pulse), .chg_pulse(chg_pulse),
        .dsg_on(dsg_on), .chg_on(chg_on), .tick(tick), .temp_step(temp_step),
        .sleep(sleep), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [7:0] exp_mode(input logic [7:0] w, input logic stc, input logic std);
        return {w[7:6], stc, std, w[3:1], 1'b0};
    endfunction

    function automatic int sd_period(input int code);
        return 1 << (15 - code);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0; d = rdata;
    endtask

    task automatic rd16(input logic [6:0] lo_a, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo_a, l);
        rd(lo_a + 7'd1, h);
        v = {h, l};
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clr(input logic [7:0] bits);
        wr(7'h74, bits);
        @(negedge clk);
    endtask

    task automatic pulse(input bit d, input bit c, input int n);
        dsg_pulse = d; chg_pulse = c;
        repeat (n) @(negedge clk);
        dsg_pulse = 1'b0; chg_pulse = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            tick = 1'b1;
            repeat (n) @(negedge clk);
            tick = 1'b0;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        logic [15:0] dcr_m, ccr_m;
        logic [7:0]  mode_w, ofs_m, rv;
        int          n, op;

        n = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd16(7'h7E, v); check("R1 dcr", v, 16'h0);
        rd16(7'h7C, v); check("R1 ccr", v, 16'h0);
        rd16(7'h7A, v); check("R1 scr", v, 16'h0);
        rd16(7'h78, v); check("R1 dtc", v, 16'h0);
        rd16(7'h76, v); check("R1 ctc", v, 16'h0);
        rd(7'h75, b);   check("R1 mode", b, 8'h0E);
        rd(7'h73, b);   check("R1 offset", b, 8'h00);
        rd(7'h74, b);   check("R1 R5 temp/clear", b, 8'h60);

        // R7 R8 R10 R12 directed
        wr(7'h75, 8'hFF); rd(7'h75, b); check("R7 mode write", b, exp_mode(8'hFF, 1'b0, 1'b0));
        wr(7'h75, 8'h0E); mode_w = 8'h0E;
        wr(7'h73, 8'h9C); rd(7'h73, b); check("R8 offset", b, 8'h9C);
        ofs_m = 8'h9C;
        wr(7'h7E, 8'h55); rd16(7'h7E, v); check("R10 write to count", v, 16'h0);
        rd(7'h10, b); check("R12 unmapped", b, 8'h00);

        // random mix
        dcr_m = '0; ccr_m = '0;
        for (int i = 0; i < 40; i++) begin
            op = $urandom_range(0, 5);
            n  = $urandom_range(1, 40);
            case (op)
                0: begin pulse(1'b1, 1'b0, n); dcr_m = dcr_m + 16'(n); end
                1: begin pulse(1'b0, 1'b1, n); ccr_m = ccr_m + 16'(n); end
                2: begin pulse(1'b1, 1'b1, n); dcr_m = dcr_m + 16'(n); ccr_m = ccr_m + 16'(n); end
                3: begin
                    ofs_m = 8'($urandom); wr(7'h73, ofs_m);
                    rd(7'h73, b); check("R8 offset random", b, ofs_m);
                end
                4: wr(7'h76 + 7'($urandom_range(0, 9)), 8'($urandom));
                default: begin
                    mode_w = 8'($urandom); wr(7'h75, mode_w);
                    rd(7'h75, b); check("R7 mode random", b, exp_mode(mode_w, 1'b0, 1'b0));
                end
            endcase
        end
        rd16(7'h7E, v); check("R2 R10 dcr model", v, dcr_m);
        rd16(7'h7C, v); check("R2 R10 ccr model", v, ccr_m);
        rd16(7'h78, v); check("R10 dtc untouched", v, 16'h0);
        rd16(7'h76, v); check("R10 ctc untouched", v, 16'h0);
        rd(7'h73, b);   check("R8 offset final", b, ofs_m);

        // R9 coherent pair read
        clr(8'h01);
        pulse(1'b1, 1'b0, 255);
        rd(7'h7E, b); check("R9 low byte", b, 8'hFF);
        pulse(1'b1, 1'b0, 1);
        rd(7'h7F, b); check("R9 latched high", b, 8'h00);
        rd16(7'h7E, v); check("R9 fresh pair", v, 16'h0100);

        // R6 self-clearing clear bits
        wr(7'h74, 8'h1F);
        rd(7'h74, b); check("R6 clear bits set", b, 8'h7F);
        rd(7'h74, b); check("R6 clear bits cleared", b, 8'h60);
        rd16(7'h7E, v); check("R6 dcr cleared", v, 16'h0);
        rd16(7'h7C, v); check("R6 ccr cleared", v, 16'h0);

        // R3 time counters
        dsg_on = 1'b1; run_ticks(10); dsg_on = 1'b0;
        chg_on = 1'b1; run_ticks(7);  chg_on = 1'b0;
        rd16(7'h78, v); check("R3 dtc", v, 16'd10);
        rd16(7'h76, v); check("R3 ctc", v, 16'd7);

        // R11 sleep freezes counting
        sleep = 1'b1;
        pulse(1'b1, 1'b1, 5);
        dsg_on = 1'b1; chg_on = 1'b1; run_ticks(20); dsg_on = 1'b0; chg_on = 1'b0;
        sleep = 1'b0;
        rd16(7'h7E, v); check("R11 dcr frozen", v, 16'h0);
        rd16(7'h7C, v); check("R11 ccr frozen", v, 16'h0);
        rd16(7'h78, v); check("R11 dtc frozen", v, 16'd10);
        rd16(7'h76, v); check("R11 ctc frozen", v, 16'd7);

        // R5 self-discharge rate per temperature step
        foreach (sd_codes[k]) begin
            temp_step = sd_codes[k];
            clr(8'h04);
            run_ticks(sd_period(sd_codes[k]) - 1);
            rd16(7'h7A, v); check("R5 scr before step", v, 16'h0);
            run_ticks(1);
            rd16(7'h7A, v); check("R5 scr at step", v, 16'h1);
        end
        rd(7'h74, b); check("R5 temp readback", b, 8'h00);

        // R11 prescaler frozen during sleep
        temp_step = 3'd7;
        clr(8'h04);
        run_ticks(200);
        sleep = 1'b1; run_ticks(100); sleep = 1'b0;
        run_ticks(55);
        rd16(7'h7A, v); check("R11 scr prescaler held", v, 16'h0);
        run_ticks(1);
        rd16(7'h7A, v); check("R11 scr resumes", v, 16'h1);

        // R4 rollover to slow mode, R6 clear restores fast mode
        dsg_on = 1'b1;
        clr(8'h08);
        run_ticks(65535);
        rd16(7'h78, v); check("R4 dtc at max", v, 16'hFFFF);
        rd(7'h75, b);   check("R4 no slow flag yet", b, exp_mode(mode_w, 1'b0, 1'b0));
        run_ticks(1);
        rd16(7'h78, v); check("R4 dtc wrapped", v, 16'h0);
        rd(7'h75, b);   check("R4 slow flag set", b, exp_mode(mode_w, 1'b0, 1'b1));
        run_ticks(255);
        rd16(7'h78, v); check("R4 slow before step", v, 16'h0);
        run_ticks(1);
        rd16(7'h78, v); check("R4 slow step", v, 16'h1);
        clr(8'h08);
        rd(7'h75, b);   check("R6 slow flag cleared", b, exp_mode(mode_w, 1'b0, 1'b0));
        run_ticks(1);
        rd16(7'h78, v); check("R6 fast rate restored", v, 16'h1);
        dsg_on = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    logic [2:0] sd_codes [3] = '{3'd7, 3'd3, 3'd0};
endmodule